// File: doc/BRIEF.md
# Scan-Testable Loadable Up-Counter

This block is a small binary up-counter whose state register doubles as a serial test path. In functional mode it counts up by one, loads a parallel word, or holds, under an enable and a load select. An asynchronous active-high clear forces the state to zero at any time.

Each state flip-flop is a multiplexed-D scan cell. When the shift-mode input is high, the cells form one chain. Bit 0 takes the serial input, each higher bit takes the bit below it, and the top bit is presented as the serial output. A tester can therefore write any state, apply one functional clock to capture the next state, and read the result back serially. The chain is as long as the counter is wide, which is four cells by default.

Top module: `scanctr_top`

## Requirements
- R1: While clr is high, q is 4'b0000 immediately, with no clock edge needed, and this holds whatever scan_en, en, ld or din are doing.
- R2: On a rising clk with scan_en low, en high and ld high, q takes the value of din.
- R3: On a rising clk with scan_en low, en high and ld low, q becomes q+1 modulo 16, so 4'b1111 is followed by 4'b0000.
- R4: On a rising clk with scan_en low and en low, q keeps its value.
- R5: On a rising clk with scan_en high, q[0] takes scan_in and each q[i] takes the old q[i-1]; en, ld and din have no effect.
- R6: scan_out always equals q[3], the last cell of the chain.
- R7: The chain is exactly 4 cells long. After the serial bits 0,0,1,1 are shifted in, in that order, q is 4'b0011. Four more shifts then present 0,0,1,1 on scan_out, with q[3] first, before each shift.
- R8: A capture sequence works as follows: scan-load a state, drive en, ld and din with scan_en low, apply one clock, then scan-unload. The unloaded word equals the functional next state of the loaded state under R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both count and shift |
| clr | input | 1 | Asynchronous active-high clear of the state |
| en | input | 1 | Functional enable; low holds the count |
| ld | input | 1 | With en high: 1 loads din, 0 increments |
| din | input | 4 | Parallel load value |
| scan_en | input | 1 | High selects serial shift through the chain |
| scan_in | input | 1 | Serial data into cell 0 |
| q | output | 4 | Counter state, driven directly by the cells |
| scan_out | output | 1 | Serial data out, equal to q[3] |

## Verification
The clear acts on q at once, so the bench checks it a fraction of a nanosecond after raising clr, before any clock edge. Load, increment, hold and each shift step show on q one edge after the inputs are applied. The bench changes inputs on the falling edge and reads q on the following falling edge. scan_out follows q[3] with no delay, so each serial bit is read before the shift edge that replaces it. In a capture sequence the result is due four shift edges after the single functional edge, and the bench compares it with a next-state value it computes itself.

// File: rtl/scanctr_pkg.sv
package scanctr_pkg;
  typedef enum logic {
    MODE_FUNC  = 1'b0,
    MODE_SHIFT = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/scanctr_next.sv
module scanctr_next #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (!en)     nxt = cur;
    else if (ld) nxt = din;
    else         nxt = cur + W'(1);
  end
endmodule

// File: rtl/scanctr_cell.sv
module scanctr_cell (
  input  logic clk,
  input  logic clr,
  input  logic se,
  input  logic d,
  input  logic si,
  output logic q
);
  logic d_sel;
  assign d_sel = se ? si : d;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) q <= 1'b0;
    else     q <= d_sel;
  end
endmodule

// File: rtl/scanctr_top.sv
module scanctr_top #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         scan_en,
  input  logic         scan_in,
  output logic [W-1:0] q,
  output logic         scan_out
);
  import scanctr_pkg::*;

  localparam int MSB = W - 1;

  scan_mode_e   mode;
  logic         shift_sel;
  logic [W-1:0] func_nxt;
  logic [W-1:0] state;

  assign mode      = scan_en ? MODE_SHIFT : MODE_FUNC;
  assign shift_sel = (mode == MODE_SHIFT);

  scanctr_next #(.W(W)) u_next (
    .cur (state),
    .en  (en),
    .ld  (ld),
    .din (din),
    .nxt (func_nxt)
  );

  for (genvar i = 0; i < W; i++) begin : g_chain
    logic ser;
    if (i == 0) begin : g_head
      assign ser = scan_in;
    end else begin : g_link
      assign ser = state[i-1];
    end
    scanctr_cell u_cell (
      .clk (clk),
      .clr (clr),
      .se  (shift_sel),
      .d   (func_nxt[i]),
      .si  (ser),
      .q   (state[i])
    );
  end

  assign q        = state;
  assign scan_out = state[MSB];

  // R1: clear forces zero without waiting for a clock edge
  always @(negedge clk) begin
    if (clr) p_clear_zero_r1: assert (q == '0);
  end

  p_load_r2: assert property (@(posedge clk) disable iff (clr)
    (!scan_en && en && ld) |=> (q == $past(din)));

  p_incr_wrap_r3: assert property (@(posedge clk) disable iff (clr)
    (!scan_en && en && !ld) |=> (q == W'($past(q) + W'(1))));

  p_hold_r4: assert property (@(posedge clk) disable iff (clr)
    (!scan_en && !en) |=> $stable(q));

  p_shift_r5: assert property (@(posedge clk) disable iff (clr)
    scan_en |=> (q == {$past(q[W-2:0]), $past(scan_in)}));
endmodule

// File: tb/scanctr_top_tb.sv
`timescale 1ns/1ps
module scanctr_top_tb;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       en = 1'b0, ld = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
  logic [3:0] din = 4'b0000;
  logic [3:0] q;
  logic       scan_out;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scanctr_top u_dut (
    .clk(clk), .clr(clr), .en(en), .ld(ld), .din(din),
    .scan_en(scan_en), .scan_in(scan_in), .q(q), .scan_out(scan_out)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic scan_load(input logic [3:0] v);
    scan_en = 1'b1;
    for (int i = 3; i >= 0; i--) begin
      scan_in = v[i];
      tick();
    end
    scan_en = 1'b0;
  endtask

  task automatic scan_unload(output logic [3:0] v, input string tag);
    scan_en = 1'b1;
    scan_in = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      chk({tag, " R6 scan_out"}, {3'b000, scan_out}, {3'b000, q[3]});
      v[i] = scan_out;
      tick();
    end
    scan_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", q, 4'b0000);
    @(negedge clk);
    clr = 1'b0;
    tick();
    chk("R4 hold after reset", q, 4'b0000);
  endtask

  task automatic t_load_count();
    en = 1'b1; ld = 1'b1; din = 4'b1110;
    tick();
    chk("R2 load", q, 4'b1110);
    ld = 1'b0;
    tick();
    chk("R3 incr", q, 4'b1111);
    tick();
    chk("R3 wrap", q, 4'b0000);
    tick();
    chk("R3 incr after wrap", q, 4'b0001);
    en = 1'b0; din = 4'b1010; ld = 1'b1;
    tick(); tick();
    chk("R4 hold ignores load", q, 4'b0001);
  endtask

  task automatic t_shift_ignores();
    logic [3:0] exp;
    exp = q;
    en = 1'b1; ld = 1'b1; din = 4'b1111;
    scan_en = 1'b1; scan_in = 1'b1;
    tick();
    exp = {exp[2:0], 1'b1};
    chk("R5 shift ignores en/ld/din", q, exp);
    en = 1'b1; ld = 1'b0; scan_in = 1'b0;
    tick();
    exp = {exp[2:0], 1'b0};
    chk("R5 shift ignores incr", q, exp);
    scan_en = 1'b0; en = 1'b0; ld = 1'b0;
  endtask

  task automatic t_chain();
    logic [3:0] got;
    scan_en = 1'b1;
    scan_in = 1'b0; tick();
    scan_in = 1'b0; tick();
    scan_in = 1'b1; tick();
    scan_in = 1'b1; tick();
    scan_en = 1'b0;
    chk("R7 chain load 0011", q, 4'b0011);
    scan_unload(got, "R7");
    chk("R7 chain unload serial 0,0,1,1", got, 4'b0011);
    chk("R7 chain flushed", q, 4'b0000);
  endtask

  task automatic t_capture(input logic [3:0] s, input logic e, input logic l, input logic [3:0] d);
    logic [3:0] got, exp;
    scan_load(s);
    en = e; ld = l; din = d;
    chk("R8 capture PO before clock", q, s);
    tick();
    en = 1'b0; ld = 1'b0;
    if (!e) exp = s;
    else if (l) exp = d;
    else exp = s + 4'd1;
    scan_unload(got, "R8");
    chk("R8 capture unload", got, exp);
  endtask

  task automatic t_async_clear();
    scan_load(4'b1011);
    chk("R5 preset before clear", q, 4'b1011);
    #1 clr = 1'b1;
    #0.5;
    chk("R1 async clear no edge", q, 4'b0000);
    @(negedge clk);
    scan_en = 1'b1; scan_in = 1'b1; en = 1'b1;
    tick();
    chk("R1 clear beats shift", q, 4'b0000);
    clr = 1'b0; scan_en = 1'b0; en = 1'b0;
  endtask

  initial begin
    #50000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_count();
    t_shift_ignores();
    t_chain();
    t_capture(4'b1111, 1'b1, 1'b0, 4'b0000);
    t_capture(4'b1010, 1'b1, 1'b1, 4'b0101);
    t_capture(4'b0110, 1'b0, 1'b1, 4'b1001);
    t_capture(4'b0111, 1'b1, 1'b0, 4'b0011);
    t_async_clear();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule